// File: doc/BRIEF.md
# Memory Zero-Fill Sequencer

This block clears a region of auxiliary memory to zero. It does no data movement itself. It drives the command side of an existing DMA engine, pointing every transfer at a fixed zero buffer in main memory. It keeps issuing write commands until the selected region is covered. A two-bit select picks the region from the sizes of the internal and expansion memories given at the inputs.

After a start pulse the sequencer latches the region, holds off until the memory reports ready, and then walks the region in chunks. Each chunk is a full 2048 bytes except the last. The last one is cut to what remains, rounded up to a 32-byte multiple. A new chunk is issued only after the engine's busy flag has dropped. After each finished chunk the sequencer acknowledges the completion, and it marks the end of the whole request with a one-cycle done pulse.

Top module: `zfill_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `dma_go_o`, `xfer_ack_o` and `done_o` are all 0.
- R2: After a start pulse with a non-empty region, no transfer is issued until `mem_ready_i` has been sampled 1. While it stays 0, `busy_o` stays 1.
- R3: Each transfer except the last is 2048 bytes long. The destination address of each transfer is the previous destination plus the previous length, starting at the region base.
- R4: When fewer than 2048 bytes remain, the final length is the remainder rounded up to the next multiple of 32. Every length is non-zero and has bits [4:0] equal to 0.
- R5: Every transfer has `dma_dir_o` = 0 (main memory to auxiliary memory) and `dma_src_o` equal to parameter `ZBUF_ADDR`. `zero_data_o` is always all zeros.
- R6: `dma_go_o` is a one-cycle pulse that is never raised while `dma_busy_i` is 1. After a transfer, the next one is issued only once busy has been seen 0. Each completion gives exactly one `xfer_ack_o` pulse.
- R7: `region_i` codes: 0 = internal memory from 0 to `int_size_i`; 1 = internal memory from 0x4000 to `int_size_i`; 2 = expansion memory from `int_size_i` to `int_size_i + exp_size_i`; 3 = no region.
- R8: A request clears nothing, yet still ends with `done_o`, in these cases: `int_size_i` is 0; code 1 with `int_size_i` <= 0x4000; code 2 with `exp_size_i` 0; code 3.
- R9: `done_o` is a single-cycle pulse raised after the last acknowledge. A start pulse seen while `busy_o` is 1, including the done cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request pulse |
| region_i | input | 2 | Region preset code |
| int_size_i | input | ADDR_W | Internal memory size in bytes |
| exp_size_i | input | ADDR_W | Expansion memory size in bytes |
| mem_ready_i | input | 1 | Memory-ready status bit |
| dma_busy_i | input | 1 | DMA engine busy flag |
| dma_go_o | output | 1 | Transfer command strobe |
| dma_dir_o | output | 1 | Direction, 0 = main to auxiliary |
| dma_src_o | output | ADDR_W | Main-memory source (zero buffer) |
| dma_dst_o | output | ADDR_W | Auxiliary destination address |
| dma_len_o | output | ADDR_W | Transfer length in bytes |
| zero_data_o | output | DATA_W | Constant zero data source |
| xfer_ack_o | output | 1 | Completion-flag clear pulse |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | End-of-request pulse |

## Verification
Two things can coincide: the done pulse of one request and a start pulse for the next. The bench provokes this by raising `start_i` in exactly the cycle where `done_o` is seen high. It then judges over the following cycles that `busy_o` stays 0 and no `dma_go_o` appears. A scoreboard also compares every issued transfer, including the rounded tail chunks, against lists computed from the region rules.

// File: rtl/zfs_pkg.sv
// Package: shared state and region codes for the zero-fill sequencer.
// Assumes nothing beyond being compiled first.
package zfs_pkg;

    // Controller states
    typedef enum logic [2:0] {
        ZS_IDLE,
        ZS_RDY,
        ZS_ISSUE,
        ZS_SETTLE,
        ZS_WAIT,
        ZS_FIN
    } zs_state_t;

    // Region preset codes (R7)
    localparam logic [1:0] RGN_FULL = 2'd0;
    localparam logic [1:0] RGN_USER = 2'd1;
    localparam logic [1:0] RGN_EXP  = 2'd2;

endpackage

// File: rtl/zfs_region.sv
// Module: zfs_region
// Turns a region code and the two memory sizes into a base address, an end
// address and an empty flag. Purely combinational.
// Assumes the sizes fit ADDR_W bits with their sum.
module zfs_region
    import zfs_pkg::*;
#(
    parameter int ADDR_W   = 27,
    parameter int RSV_BASE = 'h4000
) (
    input  logic [1:0]        sel_i,
    input  logic [ADDR_W-1:0] int_size_i,
    input  logic [ADDR_W-1:0] exp_size_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W-1:0] end_o,
    output logic              empty_o
);

    localparam logic [ADDR_W-1:0] RSV_V = ADDR_W'(RSV_BASE);

    // Decode the preset into bounds and decide whether anything must be cleared
    always_comb begin
        base_o  = '0;
        end_o   = '0;
        empty_o = 1'b1;
        case (sel_i)
            RGN_FULL: begin
                base_o  = '0;
                end_o   = int_size_i;
                empty_o = (int_size_i == '0);
            end
            RGN_USER: begin
                base_o  = RSV_V;
                end_o   = int_size_i;
                empty_o = (int_size_i <= RSV_V);
            end
            RGN_EXP: begin
                base_o  = int_size_i;
                end_o   = int_size_i + exp_size_i;
                empty_o = (int_size_i == '0) || (exp_size_i == '0);
            end
            default: begin
                empty_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/zfs_chunk.sv
// Module: zfs_chunk
// Works out the length of the next transfer from the current address and the
// region end, and whether that transfer reaches the end.
// Assumes addr_i < end_i whenever the result is used; ALIGN is a power of two.
module zfs_chunk #(
    parameter int ADDR_W = 27,
    parameter int CHUNK  = 2048,
    parameter int ALIGN  = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] end_i,
    output logic [ADDR_W-1:0] len_o,
    output logic              last_o
);

    localparam logic [ADDR_W-1:0] CHUNK_V = ADDR_W'(CHUNK);
    localparam logic [ADDR_W-1:0] AMASK   = ADDR_W'(ALIGN - 1);

    logic [ADDR_W-1:0] rem;
    logic [ADDR_W-1:0] rem_up;

    // Remaining bytes and their aligned round-up
    always_comb begin
        rem    = end_i - addr_i;
        rem_up = (rem + AMASK) & ~AMASK;
    end

    // Pick a full chunk or the rounded tail, and flag the final transfer
    always_comb begin
        len_o  = (rem < CHUNK_V) ? rem_up : CHUNK_V;
        last_o = ((addr_i + len_o) >= end_i);
    end

endmodule

// File: rtl/zfs_ctrl.sv
// Module: zfs_ctrl
// Sequencing state machine: latches the region, waits for memory ready,
// issues one transfer at a time, waits for the engine to go idle, acknowledges,
// advances, and signals done.
// Assumes the engine raises busy within one cycle of a command strobe.
module zfs_ctrl
    import zfs_pkg::*;
#(
    parameter int ADDR_W = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mem_ready_i,
    input  logic              dma_busy_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] end_i,
    input  logic              empty_i,
    input  logic [ADDR_W-1:0] len_i,
    input  logic              last_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] end_o,
    output logic              issue_o,
    output logic              ack_o,
    output logic              done_o,
    output logic              active_o
);

    zs_state_t         state;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] end_q;
    logic              rdy_seen;

    // State, cursor and bound registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ZS_IDLE;
            addr_q   <= '0;
            end_q    <= '0;
            rdy_seen <= 1'b0;
        end else begin
            case (state)
                ZS_IDLE: begin
                    if (start_i) begin
                        addr_q   <= base_i;
                        end_q    <= end_i;
                        rdy_seen <= 1'b0;
                        state    <= empty_i ? ZS_FIN : ZS_RDY;
                    end
                end
                ZS_RDY: begin
                    if (mem_ready_i) begin
                        rdy_seen <= 1'b1;
                        state    <= ZS_ISSUE;
                    end
                end
                ZS_ISSUE:  state <= ZS_SETTLE;
                ZS_SETTLE: state <= ZS_WAIT;
                ZS_WAIT: begin
                    if (!dma_busy_i) begin
                        addr_q <= addr_q + len_i;
                        state  <= last_i ? ZS_FIN : ZS_ISSUE;
                    end
                end
                ZS_FIN:  state <= ZS_IDLE;
                default: state <= ZS_IDLE;
            endcase
        end
    end

    // Decode strobes from the state
    always_comb begin
        issue_o  = (state == ZS_ISSUE);
        ack_o    = (state == ZS_WAIT) && !dma_busy_i;
        done_o   = (state == ZS_FIN);
        active_o = (state != ZS_IDLE);
        addr_o   = addr_q;
        end_o    = end_q;
    end

    // R2
    ready_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o |-> rdy_seen);

    // R6
    no_issue_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o |-> !dma_busy_i);

    // R6
    issue_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o |=> !issue_o);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !active_o));

    // R3
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !last_i) |=> (addr_q == $past(addr_q) + $past(len_i)));

endmodule

// File: rtl/zfill_seq.sv
// Module: zfill_seq
// Top of the zero-fill sequencer. Region decode, chunk sizing and the control
// state machine are joined here, and the fixed command fields are driven.
// Assumes an external DMA engine that takes a command on dma_go_o and holds
// dma_busy_i high from the next cycle until the transfer is finished.
module zfill_seq
    import zfs_pkg::*;
#(
    parameter int ADDR_W    = 27,
    parameter int DATA_W    = 32,
    parameter int CHUNK     = 2048,
    parameter int ALIGN     = 32,
    parameter int RSV_BASE  = 'h4000,
    parameter int ZBUF_ADDR = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        region_i,
    input  logic [ADDR_W-1:0] int_size_i,
    input  logic [ADDR_W-1:0] exp_size_i,
    input  logic              mem_ready_i,
    input  logic              dma_busy_i,
    output logic              dma_go_o,
    output logic              dma_dir_o,
    output logic [ADDR_W-1:0] dma_src_o,
    output logic [ADDR_W-1:0] dma_dst_o,
    output logic [ADDR_W-1:0] dma_len_o,
    output logic [DATA_W-1:0] zero_data_o,
    output logic              xfer_ack_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int AL_BITS = $clog2(ALIGN);

    logic [ADDR_W-1:0] rg_base, rg_end, cur_addr, cur_end, cur_len;
    logic              rg_empty, cur_last;

    zfs_region #(.ADDR_W(ADDR_W), .RSV_BASE(RSV_BASE)) u_region (
        .sel_i      (region_i),
        .int_size_i (int_size_i),
        .exp_size_i (exp_size_i),
        .base_o     (rg_base),
        .end_o      (rg_end),
        .empty_o    (rg_empty)
    );

    zfs_chunk #(.ADDR_W(ADDR_W), .CHUNK(CHUNK), .ALIGN(ALIGN)) u_chunk (
        .addr_i (cur_addr),
        .end_i  (cur_end),
        .len_o  (cur_len),
        .last_o (cur_last)
    );

    zfs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mem_ready_i (mem_ready_i),
        .dma_busy_i  (dma_busy_i),
        .base_i      (rg_base),
        .end_i       (rg_end),
        .empty_i     (rg_empty),
        .len_i       (cur_len),
        .last_i      (cur_last),
        .addr_o      (cur_addr),
        .end_o       (cur_end),
        .issue_o     (dma_go_o),
        .ack_o       (xfer_ack_o),
        .done_o      (done_o),
        .active_o    (busy_o)
    );

    // Fixed command fields: write direction, zero buffer, zero data
    always_comb begin
        dma_dir_o   = 1'b0;
        dma_src_o   = ADDR_W'(ZBUF_ADDR);
        zero_data_o = '0;
        dma_dst_o   = cur_addr;
        dma_len_o   = cur_len;
    end

    // R4
    len_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_go_o |-> (dma_len_o[AL_BITS-1:0] == '0 && dma_len_o != '0
                      && dma_len_o <= ADDR_W'(CHUNK)));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!dma_go_o && !xfer_ack_o));

endmodule

// File: tb/sim_zfill_seq.sv
module sim_zfill_seq;

    localparam int AW = 27;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    region_i = 2'd0;
    logic [AW-1:0] int_size_i = '0;
    logic [AW-1:0] exp_size_i = '0;
    logic          mem_ready_i = 1'b1;
    logic          dma_busy_i;
    logic          dma_go_o, dma_dir_o, xfer_ack_o, busy_o, done_o;
    logic [AW-1:0] dma_src_o, dma_dst_o, dma_len_o;
    logic [31:0]   zero_data_o;

    int checks = 0;
    int fails  = 0;
    int go_cnt = 0;
    int ack_cnt = 0;
    logic [AW-1:0] exp_addr_q[$];
    logic [AW-1:0] exp_len_q[$];

    always #2 clk = ~clk;

    zfill_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .region_i(region_i),
        .int_size_i(int_size_i), .exp_size_i(exp_size_i),
        .mem_ready_i(mem_ready_i), .dma_busy_i(dma_busy_i),
        .dma_go_o(dma_go_o), .dma_dir_o(dma_dir_o), .dma_src_o(dma_src_o),
        .dma_dst_o(dma_dst_o), .dma_len_o(dma_len_o), .zero_data_o(zero_data_o),
        .xfer_ack_o(xfer_ack_o), .busy_o(busy_o), .done_o(done_o)
    );

    // DMA engine model: busy from the cycle after a command, for five cycles
    int dcnt = 0;
    logic dbusy = 1'b0;
    assign dma_busy_i = dbusy;
    always @(posedge clk) begin
        if (!rst_n) begin
            dbusy <= 1'b0;
            dcnt  <= 0;
        end else if (dma_go_o && !dbusy) begin
            dbusy <= 1'b1;
            dcnt  <= 4;
        end else if (dbusy) begin
            if (dcnt == 0) dbusy <= 1'b0;
            else dcnt <= dcnt - 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Monitor: pop and compare each issued transfer
    always @(negedge clk) begin
        if (rst_n && dma_go_o) begin
            go_cnt++;
            check(dbusy == 1'b0, "R6", "go while busy", dbusy, 0);
            check(dma_dir_o == 1'b0 && dma_src_o == AW'('h100) && zero_data_o == '0,
                  "R5", "fixed fields", dma_src_o, 'h100);
            if (exp_addr_q.size() == 0) begin
                check(1'b0, "R3", "unexpected transfer", dma_dst_o, 0);
            end else begin
                logic [AW-1:0] ea, el;
                ea = exp_addr_q.pop_front();
                el = exp_len_q.pop_front();
                check(dma_dst_o == ea, "R3", "dest address", dma_dst_o, ea);
                check(dma_len_o == el, "R4", "length", dma_len_o, el);
            end
        end
        if (rst_n && xfer_ack_o) ack_cnt++;
    end

    // Driver: compute the expected transfer list from R7/R8 and push it
    task automatic push_expected(input logic [1:0] sel, input logic [AW-1:0] isz,
                                 input logic [AW-1:0] esz, output int n);
        longint b, e, a, l, r;
        bit ok;
        n = 0; b = 0; e = 0; ok = 0;
        case (sel)
            2'd0: begin b = 0;      e = isz;       ok = (isz != 0); end
            2'd1: begin b = 'h4000; e = isz;       ok = (isz > 'h4000); end
            2'd2: begin b = isz;    e = isz + esz; ok = (isz != 0) && (esz != 0); end
            default: ok = 0;
        endcase
        if (ok) begin
            a = b;
            while (a < e) begin
                r = e - a;
                l = ((r + 31) / 32) * 32;
                if (l > 2048) l = 2048;
                exp_addr_q.push_back(AW'(a));
                exp_len_q.push_back(AW'(l));
                a = a + l;
                n++;
            end
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 20000 && !seen; i++) begin
            if (done_o) seen = 1;
            else @(negedge clk);
        end
    endtask

    task automatic run_req(input logic [1:0] sel, input logic [AW-1:0] isz,
                           input logic [AW-1:0] esz, input string req);
        int n, g0, a0;
        bit seen;
        @(negedge clk);
        region_i = sel; int_size_i = isz; exp_size_i = esz;
        push_expected(sel, isz, esz, n);
        g0 = go_cnt; a0 = ack_cnt;
        pulse_start();
        wait_done(seen);
        check(seen, req, "done seen", seen, 1);
        check(go_cnt - g0 == n, req, "transfer count", go_cnt - g0, n);
        check(ack_cnt - a0 == n, "R6", "ack count", ack_cnt - a0, n);
        check(exp_addr_q.size() == 0, req, "leftover expected", exp_addr_q.size(), 0);
        @(negedge clk);
        check(done_o == 1'b0 && busy_o == 1'b0, "R9", "done single cycle", done_o, 0);
        exp_addr_q.delete(); exp_len_q.delete();
    endtask

    initial begin
        int n, g0;
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy_o && !dma_go_o && !xfer_ack_o && !done_o, "R1", "reset idle",
              {busy_o, dma_go_o, xfer_ack_o, done_o}, 0);

        // R2: hold ready low, no transfer may appear
        mem_ready_i = 1'b0;
        region_i = 2'd1; int_size_i = AW'('h5000); exp_size_i = '0;
        push_expected(2'd1, AW'('h5000), '0, n);
        g0 = go_cnt;
        pulse_start();
        repeat (20) @(negedge clk);
        check(go_cnt == g0, "R2", "no go before ready", go_cnt - g0, 0);
        check(busy_o == 1'b1, "R2", "busy while waiting", busy_o, 1);
        mem_ready_i = 1'b1;
        wait_done(seen);
        check(seen && go_cnt - g0 == n, "R2", "clear after ready", go_cnt - g0, n);
        @(negedge clk);
        exp_addr_q.delete(); exp_len_q.delete();

        // R3/R7: full internal region, whole chunks
        run_req(2'd0, AW'('h5000), '0, "R3");
        // R4: unaligned tail 33 bytes -> 64
        run_req(2'd0, AW'('h4821), '0, "R4");
        // R7: expansion region with a 528-byte tail -> 544
        run_req(2'd2, AW'('h5000), AW'('h0A10), "R7");
        // R7: user region
        run_req(2'd1, AW'('h4300), '0, "R7");
        // R8: empty cases
        run_req(2'd0, '0, AW'('h1000), "R8");
        run_req(2'd2, AW'('h5000), '0, "R8");
        run_req(2'd2, '0, AW'('h1000), "R8");
        run_req(2'd1, AW'('h4000), '0, "R8");
        run_req(2'd3, AW'('h5000), AW'('h1000), "R8");

        // R9: start coinciding with done is ignored
        region_i = 2'd0; int_size_i = AW'('h0040); exp_size_i = '0;
        push_expected(2'd0, AW'('h0040), '0, n);
        pulse_start();
        wait_done(seen);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        g0 = go_cnt;
        repeat (30) @(negedge clk);
        check(go_cnt == g0 && busy_o == 1'b0, "R9", "start in done cycle ignored",
              go_cnt - g0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule